// File: doc/BRIEF.md
# Banked Data Memory Access Unit

This block is the data-side memory port of a small 8-bit controller. One access per cycle comes in as an 8-bit address with separate read and write strobes. The unit decides whether the access is direct or goes through one of two pointer registers, applies a bank register where that applies, and routes the access to general-purpose RAM, to a small display RAM, to its own pointer registers, or out to a stub port that stands in for the rest of the special-function registers.

Two addresses hold no data: an access there is redirected through a pointer. Location 00H uses the first pointer (kept at 01H) and location 02H uses the second pointer (kept at 03H). The bank register at 04H only affects accesses that go through the second pointer; everything else always lands in the main bank. The display RAM lives in bank 15 and is also driven out as a flat vector, one bit per dot, so a display driver can scan it without using the access port.

Top module: `dmem_unit`

## Requirements
- R1: In the main bank, addresses 40H to FFH are 192 bytes of RAM; a write with `wr_en` high lands on the rising clock edge, and a read returns the stored byte in the same cycle, combinationally from the address.
- R2: Address 01H holds pointer P0, 03H holds pointer P1 (8 bits each) and 04H holds the bank register; the bank register keeps only the five low bits of a write, and its three upper bits read as 0.
- R3: After reset, P0, P1 and the bank register all read 00H.
- R4: An access to address 00H is performed at the address held in P0, and an access to 02H at the address held in P1.
- R5: When the pointer used by an access to 00H or 02H itself holds 00H or 02H, the read returns 00H and the write changes nothing and raises no stub strobe.
- R6: Addresses 30H to 3FH of the main bank read as 00H; writes to them change nothing and raise no stub strobe.
- R7: Main-bank addresses 05H to 2FH go to the stub port: `sfr_addr` carries the resolved address, `sfr_rd`/`sfr_wr` follow the strobes, `sfr_wdata` carries the write data and the read returns `sfr_rdata`; no other address raises a stub strobe.
- R8: With the bank register at 15, an access through P1 to 80H to A7H reads and writes display RAM; byte 80H+k drives `dots[8k+7:8k]`, bit b of that byte on `dots[8k+b]`, and a 1 means the dot is lit.
- R9: Direct accesses and accesses through P0 always use the main bank, whatever the bank register holds.
- R10: An access through P1 with a nonzero bank register that does not hit bank 15 at 80H to A7H reads 00H, changes nothing and raises no stub strobe.
- R11: While `rd_en` is low, `rdata` is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the block through a synchroniser |
| addr | input | 8 | Access address as issued by the core |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| sfr_addr | output | 8 | Resolved address for the special-function stub |
| sfr_rd | output | 1 | Read strobe toward the stub |
| sfr_wr | output | 1 | Write strobe toward the stub |
| sfr_wdata | output | 8 | Write data toward the stub |
| sfr_rdata | input | 8 | Read data returned by the stub |
| dots | output | 320 | Display RAM contents, one bit per dot |

## Verification
The assertions take for granted that the address, strobes and write data are held steady across each rising edge and that the stub answers combinationally from `sfr_addr`, so that a read sampled after the edge reflects only the current access. They are also gated by the internally synchronised reset, so nothing is claimed during the cycles the reset release takes to propagate. The stimulus changes inputs only on the falling edge, waits out the synchroniser after every reset, and writes every RAM byte before any check relies on its contents.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BANK_W = 5;

  // Locations whose values the decode depends on
  localparam logic [ADDR_W-1:0] LOC_IND0 = 8'h00;
  localparam logic [ADDR_W-1:0] LOC_P0   = 8'h01;
  localparam logic [ADDR_W-1:0] LOC_IND1 = 8'h02;
  localparam logic [ADDR_W-1:0] LOC_P1   = 8'h03;
  localparam logic [ADDR_W-1:0] LOC_BANK = 8'h04;
  localparam logic [ADDR_W-1:0] SFR_LO   = 8'h05;
  localparam logic [ADDR_W-1:0] SFR_HI   = 8'h2F;
  localparam logic [ADDR_W-1:0] GP_LO    = 8'h40;
  localparam logic [ADDR_W-1:0] DOT_LO   = 8'h80;

  localparam int DOT_BYTES = 40;
  localparam int GP_BYTES  = (1 << ADDR_W) - int'(GP_LO);
  localparam int DOT_BITS  = DOT_BYTES * DATA_W;
  localparam logic [ADDR_W-1:0] DOT_HI = DOT_LO + ADDR_W'(DOT_BYTES - 1);

  localparam logic [BANK_W-1:0] BANK_MAIN = '0;
  localparam logic [BANK_W-1:0] BANK_DOT  = 5'd15;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_GP,
    TGT_DOT,
    TGT_P0,
    TGT_P1,
    TGT_BANK,
    TGT_SFR
  } tgt_e;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode import dmem_pkg::*; (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] p0,
  input  logic [ADDR_W-1:0] p1,
  input  logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] ea,
  output tgt_e              tgt
);

  logic via_p0;
  logic via_p1;
  logic ptr_loops;

  always_comb begin
    via_p0 = (addr == LOC_IND0);
    via_p1 = (addr == LOC_IND1);

    if (via_p0)      ea = p0;
    else if (via_p1) ea = p1;
    else             ea = addr;

    // a pointer aimed at an alias location resolves to nothing
    ptr_loops = (via_p0 || via_p1) && ((ea == LOC_IND0) || (ea == LOC_IND1));

    tgt = TGT_NONE;
    if (ptr_loops) begin
      tgt = TGT_NONE;
    end else if (via_p1 && (bank != BANK_MAIN)) begin
      if ((bank == BANK_DOT) && (ea >= DOT_LO) && (ea <= DOT_HI))
        tgt = TGT_DOT;
    end else begin
      if (ea == LOC_P0)                         tgt = TGT_P0;
      else if (ea == LOC_P1)                    tgt = TGT_P1;
      else if (ea == LOC_BANK)                  tgt = TGT_BANK;
      else if ((ea >= SFR_LO) && (ea <= SFR_HI)) tgt = TGT_SFR;
      else if (ea >= GP_LO)                     tgt = TGT_GP;
      else                                      tgt = TGT_NONE;
    end
  end

endmodule

// File: rtl/dmem_ptr_regs.sv
module dmem_ptr_regs import dmem_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] p0,
  output logic [ADDR_W-1:0] p1,
  output logic [BANK_W-1:0] bank
);

  logic [ADDR_W-1:0] p0_q,   p0_d;
  logic [ADDR_W-1:0] p1_q,   p1_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    p0_d   = p0_q;
    p1_d   = p1_q;
    bank_d = bank_q;
    if (we) begin
      unique case (tgt)
        TGT_P0:   p0_d   = wdata;
        TGT_P1:   p1_d   = wdata;
        TGT_BANK: bank_d = wdata[BANK_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q   <= '0;
      p1_q   <= '0;
      bank_q <= '0;
    end else begin
      p0_q   <= p0_d;
      p1_q   <= p1_d;
      bank_q <= bank_d;
    end
  end

  assign p0   = p0_q;
  assign p1   = p1_q;
  assign bank = bank_q;

endmodule

// File: rtl/dmem_gpram.sv
module dmem_gpram import dmem_pkg::*; (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] ea,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd
);

  localparam int IDX_W = $clog2(GP_BYTES);

  logic [DATA_W-1:0] mem_q [GP_BYTES];
  logic [IDX_W-1:0]  idx;

  assign idx = IDX_W'(ea - GP_LO);
  assign rd  = mem_q[idx];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

endmodule

// File: rtl/dmem_dotram.sv
module dmem_dotram import dmem_pkg::*; (
  input  logic                clk,
  input  logic                we,
  input  logic [ADDR_W-1:0]   ea,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rd,
  output logic [DOT_BITS-1:0] dots
);

  localparam int IDX_W = $clog2(DOT_BYTES);

  logic [DATA_W-1:0] mem_q [DOT_BYTES];
  logic [IDX_W-1:0]  idx;

  assign idx = IDX_W'(ea - DOT_LO);
  assign rd  = mem_q[idx];

  always_ff @(posedge clk) begin
    if (we) mem_q[idx] <= wdata;
  end

  for (genvar k = 0; k < DOT_BYTES; k++) begin : g_flat
    assign dots[k*DATA_W +: DATA_W] = mem_q[k];
  end

endmodule

// File: rtl/dmem_unit.sv
module dmem_unit import dmem_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   sfr_addr,
  output logic                sfr_rd,
  output logic                sfr_wr,
  output logic [DATA_W-1:0]   sfr_wdata,
  input  logic [DATA_W-1:0]   sfr_rdata,
  output logic [DOT_BITS-1:0] dots
);

  // reset: asserted at once, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rsync_q, rsync_d;
  logic                   rst_q_n;

  always_comb rsync_d = {rsync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= rsync_d;
  end

  assign rst_q_n = rsync_q[SYNC_STAGES-1];

  logic [ADDR_W-1:0] p0, p1, ea;
  logic [BANK_W-1:0] bank;
  tgt_e              tgt;
  logic [DATA_W-1:0] gp_rd, dot_rd, sel_rd;
  logic              gp_we, dot_we;

  dmem_decode u_decode (
    .addr (addr),
    .p0   (p0),
    .p1   (p1),
    .bank (bank),
    .ea   (ea),
    .tgt  (tgt)
  );

  dmem_ptr_regs u_ptr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (wr_en),
    .tgt   (tgt),
    .wdata (wdata),
    .p0    (p0),
    .p1    (p1),
    .bank  (bank)
  );

  assign gp_we  = wr_en && (tgt == TGT_GP);
  assign dot_we = wr_en && (tgt == TGT_DOT);

  dmem_gpram u_gp (
    .clk   (clk),
    .we    (gp_we),
    .ea    (ea),
    .wdata (wdata),
    .rd    (gp_rd)
  );

  dmem_dotram u_dot (
    .clk   (clk),
    .we    (dot_we),
    .ea    (ea),
    .wdata (wdata),
    .rd    (dot_rd),
    .dots  (dots)
  );

  always_comb begin
    unique case (tgt)
      TGT_GP:   sel_rd = gp_rd;
      TGT_DOT:  sel_rd = dot_rd;
      TGT_P0:   sel_rd = p0;
      TGT_P1:   sel_rd = p1;
      TGT_BANK: sel_rd = {{(DATA_W-BANK_W){1'b0}}, bank};
      TGT_SFR:  sel_rd = sfr_rdata;
      default:  sel_rd = '0;
    endcase
    rdata = rd_en ? sel_rd : '0;
  end

  assign sfr_addr  = ea;
  assign sfr_wdata = wdata;
  assign sfr_rd    = rd_en && (tgt == TGT_SFR);
  assign sfr_wr    = wr_en && (tgt == TGT_SFR);

endmodule

// File: rtl/dmem_unit_chk.sv
module dmem_unit_chk import dmem_pkg::*; (
  input logic                clk,
  input logic                rst_q_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                rd_en,
  input logic                wr_en,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rdata,
  input logic [ADDR_W-1:0]   sfr_addr,
  input logic                sfr_wr,
  input logic [DATA_W-1:0]   sfr_wdata,
  input logic [ADDR_W-1:0]   p0,
  input logic [BANK_W-1:0]   bank,
  input logic [DOT_BITS-1:0] dots
);

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_en |-> (rdata == '0));

  // R6
  unused_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && (addr >= 8'h30) && (addr <= 8'h3F)) |-> (rdata == '0));

  // R5
  looped_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && (addr == LOC_IND0) && ((p0 == LOC_IND0) || (p0 == LOC_IND1)))
      |-> (rdata == '0));

  // R2
  bank_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && (addr == LOC_BANK)) |-> (rdata[DATA_W-1:BANK_W] == '0));

  // R2
  p0_direct_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && (addr == LOC_P0)) |=> (p0 == $past(wdata)));

  // R7
  stub_write_window_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    sfr_wr |-> (wr_en && (sfr_wdata == wdata) && (sfr_addr >= SFR_LO) && (sfr_addr <= SFR_HI)));

  // R8
  dots_only_via_p1_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(wr_en && (addr == LOC_IND1) && (bank == BANK_DOT)) |=> $stable(dots));

endmodule

bind dmem_unit dmem_unit_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .addr      (addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .sfr_addr  (sfr_addr),
  .sfr_wr    (sfr_wr),
  .sfr_wdata (sfr_wdata),
  .p0        (p0),
  .bank      (bank),
  .dots      (dots)
);

// File: tb/dmem_unit_tb.sv
module dmem_unit_tb;

  logic         clk;
  logic         rst_n;
  logic [7:0]   addr;
  logic         rd_en;
  logic         wr_en;
  logic [7:0]   wdata;
  logic [7:0]   rdata;
  logic [7:0]   sfr_addr;
  logic         sfr_rd;
  logic         sfr_wr;
  logic [7:0]   sfr_wdata;
  logic [7:0]   sfr_rdata;
  logic [319:0] dots;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference state
  int  m_p0, m_p1, m_bank;
  int  m_gp  [256];
  bit  m_gpk [256];
  int  m_dot [40];
  bit  m_dotk[40];

  dmem_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .sfr_addr  (sfr_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .dots      (dots)
  );

  // stub answers with a pattern of the address it sees
  assign sfr_rdata = sfr_addr ^ 8'hC3;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 gp, 2 dot, 3 p0, 4 p1, 5 bank, 6 stub
  task automatic resolve(input int a, output int kind, output int ea);
    if (a == 0)      ea = m_p0;
    else if (a == 2) ea = m_p1;
    else             ea = a;
    if ((a == 0 || a == 2) && (ea == 0 || ea == 2)) kind = 0;
    else if (a == 2 && m_bank != 0)
      kind = (m_bank == 15 && ea >= 128 && ea <= 167) ? 2 : 0;
    else if (ea == 1) kind = 3;
    else if (ea == 3) kind = 4;
    else if (ea == 4) kind = 5;
    else if (ea >= 5 && ea <= 47) kind = 6;
    else if (ea >= 64) kind = 1;
    else kind = 0;
  endtask

  task automatic model_reset();
    m_p0 = 0; m_p1 = 0; m_bank = 0;
  endtask

  task automatic op(input bit rd, input bit wr, input int a, input int d, input string req);
    int  kind, ea, exp;
    bit  known;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = 8'(a); wdata = 8'(d);
    #1;
    resolve(a, kind, ea);
    known = 1;
    case (kind)
      1: begin exp = m_gp[ea];        known = m_gpk[ea]; end
      2: begin exp = m_dot[ea - 128]; known = m_dotk[ea - 128]; end
      3: exp = m_p0;
      4: exp = m_p1;
      5: exp = m_bank;
      6: exp = ea ^ 'hC3;
      default: exp = 0;
    endcase
    if (!rd) begin exp = 0; known = 1; end
    if (known) check(rdata == 8'(exp), req, "rdata", rdata, exp);
    check(sfr_rd == (rd && kind == 6), req, "sfr_rd", sfr_rd, int'(rd && kind == 6));
    check(sfr_wr == (wr && kind == 6), req, "sfr_wr", sfr_wr, int'(wr && kind == 6));
    if (kind == 6 && (rd || wr))
      check(sfr_addr == 8'(ea), req, "sfr_addr", sfr_addr, ea);
    if (kind == 6 && wr)
      check(sfr_wdata == 8'(d), req, "sfr_wdata", sfr_wdata, d);
    for (int k = 0; k < 40; k++)
      if (m_dotk[k])
        check(dots[k*8 +: 8] == 8'(m_dot[k]), "R8", "dots byte", dots[k*8 +: 8], m_dot[k]);
    @(posedge clk);
    if (wr) begin
      case (kind)
        1: begin m_gp[ea] = d & 255; m_gpk[ea] = 1; end
        2: begin m_dot[ea - 128] = d & 255; m_dotk[ea - 128] = 1; end
        3: m_p0 = d & 255;
        4: m_p1 = d & 255;
        5: m_bank = d & 31;
        default: ;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_en = 0; wr_en = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
    for (int i = 0; i < 256; i++) begin m_gp[i] = 0; m_gpk[i] = 0; end
    for (int i = 0; i < 40; i++)  begin m_dot[i] = 0; m_dotk[i] = 0; end
    model_reset();
    do_reset();

    // R3 reset state of pointers and bank
    op(1, 0, 'h01, 0, "R3"); op(1, 0, 'h03, 0, "R3"); op(1, 0, 'h04, 0, "R3");
    // R11 idle read
    op(0, 0, 'h01, 0, "R11");

    // R2 pointer and bank registers
    op(0, 1, 'h01, 'h45, "R2"); op(1, 0, 'h01, 0, "R2");
    op(0, 1, 'h03, 'h9A, "R2"); op(1, 0, 'h03, 0, "R2");
    op(0, 1, 'h04, 'hE3, "R2"); op(1, 0, 'h04, 0, "R2");
    op(0, 1, 'h04, 'h00, "R2");

    // R1 direct general RAM, including both ends
    for (int a = 'h40; a < 'h50; a++) op(0, 1, a, a * 7 + 1, "R1");
    op(0, 1, 'hFF, 'h5C, "R1"); op(0, 1, 'h80, 'h11, "R1"); op(0, 1, 'hA7, 'h22, "R1");
    for (int a = 'h40; a < 'h50; a++) op(1, 0, a, 0, "R1");
    op(1, 0, 'hFF, 0, "R1");
    op(1, 1, 'h41, 'hEE, "R1"); op(1, 0, 'h41, 0, "R1");

    // R4 indirect through P0 and P1
    op(0, 1, 'h01, 'h60, "R4"); op(0, 1, 'h00, 'hA5, "R4"); op(1, 0, 'h60, 0, "R4");
    op(0, 1, 'h03, 'h61, "R4"); op(0, 1, 'h02, 'h3C, "R4"); op(1, 0, 'h02, 0, "R4");
    op(0, 1, 'h03, 'h01, "R4"); op(0, 1, 'h02, 'h77, "R4"); op(1, 0, 'h01, 0, "R4");

    // R5 pointers aimed at alias locations
    op(0, 1, 'h01, 'h00, "R5"); op(1, 1, 'h00, 'h99, "R5");
    op(0, 1, 'h01, 'h02, "R5"); op(1, 1, 'h00, 'h98, "R5");
    op(0, 1, 'h03, 'h00, "R5"); op(1, 1, 'h02, 'h97, "R5");
    op(0, 1, 'h03, 'h02, "R5"); op(1, 1, 'h02, 'h96, "R5");
    op(1, 0, 'h01, 0, "R5"); op(1, 0, 'h03, 0, "R5");

    // R6 unused gap
    op(0, 1, 'h30, 'hFF, "R6"); op(1, 0, 'h30, 0, "R6");
    op(0, 1, 'h3F, 'hFF, "R6"); op(1, 0, 'h3F, 0, "R6");
    op(0, 1, 'h01, 'h35, "R6"); op(1, 1, 'h00, 'h12, "R6");

    // R7 stub window edges, direct and indirect
    op(1, 0, 'h05, 0, "R7"); op(0, 1, 'h2F, 'h6B, "R7"); op(1, 1, 'h1E, 'h4D, "R7");
    op(0, 1, 'h03, 'h22, "R7"); op(1, 1, 'h02, 'h19, "R7");

    // R8 display RAM through P1 with bank 15
    op(0, 1, 'h04, 'h0F, "R8");
    op(0, 1, 'h03, 'h80, "R8"); op(0, 1, 'h02, 'h81, "R8"); op(1, 0, 'h02, 0, "R8");
    op(0, 1, 'h03, 'hA7, "R8"); op(0, 1, 'h02, 'hF0, "R8"); op(1, 0, 'h02, 0, "R8");
    for (int k = 1; k < 39; k++) begin
      op(0, 1, 'h03, 'h80 + k, "R8"); op(0, 1, 'h02, k ^ 'h5A, "R8");
    end

    // R9 direct and P0 ignore the bank
    op(1, 0, 'h80, 0, "R9"); op(1, 0, 'hA7, 0, "R9");
    op(0, 1, 'h01, 'h80, "R9"); op(1, 0, 'h00, 0, "R9"); op(0, 1, 'h00, 'h3E, "R9");
    op(1, 0, 'h80, 0, "R9"); op(1, 0, 'h05, 0, "R9");

    // R10 P1 outside the display window or in another bank
    op(0, 1, 'h03, 'h7F, "R10"); op(1, 1, 'h02, 'h44, "R10");
    op(0, 1, 'h03, 'hA8, "R10"); op(1, 1, 'h02, 'h44, "R10");
    op(0, 1, 'h03, 'h10, "R10"); op(1, 1, 'h02, 'h44, "R10");
    op(0, 1, 'h03, 'h04, "R10"); op(1, 1, 'h02, 'h00, "R10"); op(1, 0, 'h04, 0, "R10");
    op(0, 1, 'h04, 'h03, "R10"); op(0, 1, 'h03, 'h80, "R10"); op(1, 1, 'h02, 'h44, "R10");
    op(0, 1, 'h04, 'h00, "R10"); op(1, 0, 'h02, 0, "R10");

    // R3 reset in mid-run
    op(0, 1, 'h01, 'hCD, "R3"); op(0, 1, 'h04, 'h0F, "R3");
    do_reset();
    op(1, 0, 'h01, 0, "R3"); op(1, 0, 'h03, 0, "R3"); op(1, 0, 'h04, 0, "R3");

    // mixed traffic against the model
    for (int i = 0; i < 1500; i++) begin
      int a, sel;
      sel = $urandom_range(0, 9);
      if (sel < 3)      a = $urandom_range(0, 4);
      else if (sel < 5) a = $urandom_range('h80, 'hA8);
      else              a = $urandom_range(0, 255);
      if (a == 4 && $urandom_range(0, 1) == 1)
        op(0, 1, 4, ($urandom_range(0, 1) == 1) ? 15 : $urandom_range(0, 31), "R10");
      else
        op($urandom_range(0, 1), $urandom_range(0, 1), a, $urandom_range(0, 255), "R1");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule